// File: doc/BRIEF.md
# ETU Time-Out Counter

This block measures waiting times on a smart card line in elementary time units (ETUs). The host writes a count into three byte registers and then writes a configuration byte. The configuration decides two things. First, whether the count is one 24-bit counter, or a 16-bit counter plus an independent 8-bit counter. Second, what starts each counter: the configuration write itself, the first detected start bit on the card line, or auto-reload operation.

Each counter decrements on an ETU tick that comes from outside the block. When a counter runs out, it sets a sticky expiry flag. The interrupt request is high while any flag is set. The host clears the flags by pulsing the status-read input.

Top module: `etu_timeout`

## Requirements
- R1: After reset, both expiry flags and the interrupt are low, and all three count bytes are zero.
- R2: Byte addresses are fixed: 0 holds count bits 7:0, 1 holds bits 15:8 and 2 holds bits 23:16. Address 3 is the configuration byte: bits 1:0 are the main counter mode, bits 3:2 the aux counter mode, and bit 4 selects split operation. The mode codes are 0 stop, 1 start on write, 2 start on start bit, 3 auto-reload.
- R3: In unsplit operation, the main counter uses all 24 bits. In start-on-write mode, `exp_main` is set on the edge of the N-th tick after the configuration write, where N is the programmed count.
- R4: In split operation, the main counter uses bits 15:0 only and the aux counter uses bits 23:16. The two counters run independently. With split off, the aux counter never expires.
- R5: In start-bit mode, ticks before the first `start_bit` pulse are not counted. Counting from the full value begins at that pulse.
- R6: In auto-reload mode, an expiring counter reloads from the count registers as they are at that moment. It keeps running and sets its flag again on each expiry.
- R7: A configuration write with mode 0 halts that counter, and the expiry flags keep their value.
- R8: `stat_rd` clears both flags. If an expiry happens in the same cycle, that flag stays set.
- R9: `irq` equals the OR of the two expiry flags in every cycle.
- R10: A counter in start-on-write or start-bit mode stops after its single expiry.
- R11: A programmed count of 0 or 1 expires on the first tick. A configuration write takes precedence over a tick or a start bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| etu_tick | input | 1 | One-cycle pulse per elapsed ETU |
| start_bit | input | 1 | One-cycle pulse when a start bit is detected on the card line |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0..2 count bytes, 3 configuration) |
| wr_data | input | 8 | Write data |
| stat_rd | input | 1 | Status-read pulse; clears the expiry flags |
| exp_main | output | 1 | Sticky expiry flag of the 24-bit or 16-bit counter |
| exp_aux | output | 1 | Sticky expiry flag of the 8-bit counter |
| irq | output | 1 | Interrupt request, high while a flag is set |

## Verification
The case that matters is a counter expiring in the same cycle as the host's status read. The bench provokes it by pulsing `stat_rd` together with the final tick, both directly and many times in the random phase. It then judges that the flag survives and is cleared only by a later read. A second collision, a configuration write landing on a tick or a start bit, is also produced at random. A cycle-accurate bench model, written from the requirements, decides the expected flags.

// File: rtl/etu_timeout_pkg.sv
package etu_timeout_pkg;
  typedef enum logic [1:0] {
    TM_STOP     = 2'd0,
    TM_ON_WRITE = 2'd1,
    TM_ON_START = 2'd2,
    TM_AUTO     = 2'd3
  } tmode_e;

  typedef struct packed {
    logic   split;
    tmode_e aux_mode;
    tmode_e main_mode;
  } etu_cfg_t;

  localparam int CFG_W    = $bits(etu_cfg_t);
  localparam int CFG_ADDR = 3;
endpackage

// File: rtl/etu_load_regs.sv
module etu_load_regs #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 3,
  parameter int ADDR_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [BYTE_W-1:0]        wr_data,
  output logic [NBYTES*BYTE_W-1:0] value
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= '0;
      else if (wr_en && wr_addr == ADDR_W'(i))
        q <= wr_data;
    end
    assign value[i*BYTE_W +: BYTE_W] = q;
  end
endmodule

// File: rtl/etu_down_counter.sv
module etu_down_counter
  import etu_timeout_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         start_bit,
  input  logic         arm,
  input  tmode_e       mode,
  input  logic [W-1:0] load_val,
  output logic         fire
);
  logic [W-1:0] cnt_q;
  logic         run_q, wait_q, auto_q;
  logic         at_end;

  assign at_end = (cnt_q <= W'(1));
  assign fire   = run_q && tick && !arm && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      wait_q <= 1'b0;
      auto_q <= 1'b0;
    end else if (arm) begin
      cnt_q <= load_val;
      case (mode)
        TM_STOP: begin
          run_q <= 1'b0; wait_q <= 1'b0; auto_q <= 1'b0;
        end
        TM_ON_WRITE: begin
          run_q <= 1'b1; wait_q <= 1'b0; auto_q <= 1'b0;
        end
        TM_ON_START: begin
          run_q <= 1'b0; wait_q <= 1'b1; auto_q <= 1'b0;
        end
        default: begin
          run_q <= 1'b1; wait_q <= 1'b0; auto_q <= 1'b1;
        end
      endcase
    end else if (wait_q && start_bit) begin
      run_q  <= 1'b1;
      wait_q <= 1'b0;
      cnt_q  <= load_val;
    end else if (fire) begin
      if (auto_q)
        cnt_q <= load_val;
      else
        run_q <= 1'b0;
    end else if (run_q && tick) begin
      cnt_q <= cnt_q - W'(1);
    end
  end
endmodule

// File: rtl/etu_timeout.sv
module etu_timeout
  import etu_timeout_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              etu_tick,
  input  logic              start_bit,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              stat_rd,
  output logic              exp_main,
  output logic              exp_aux,
  output logic              irq
);
  localparam int NBYTES = 3;
  localparam int ADDR_W = 2;
  localparam int MAIN_W = NBYTES * BYTE_W;
  localparam int LOW_W  = 2 * BYTE_W;

  logic [MAIN_W-1:0] count_regs;
  logic [MAIN_W-1:0] main_load;
  logic [BYTE_W-1:0] aux_load;
  etu_cfg_t          cfg_q, cfg_new, cfg_eff;
  logic              cfg_we;
  tmode_e            aux_mode_eff;
  logic              main_fire, aux_fire;
  logic              main_n, aux_n;
  logic              cfg_split;

  etu_load_regs #(.BYTE_W(BYTE_W), .NBYTES(NBYTES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .value(count_regs)
  );

  assign cfg_we  = wr_en && (wr_addr == ADDR_W'(CFG_ADDR));
  assign cfg_new = etu_cfg_t'(wr_data[CFG_W-1:0]);
  assign cfg_eff = cfg_we ? cfg_new : cfg_q;
  assign cfg_split = cfg_q.split;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_new;
  end

  assign main_load    = cfg_eff.split ? {{BYTE_W{1'b0}}, count_regs[LOW_W-1:0]}
                                      : count_regs;
  assign aux_load     = count_regs[MAIN_W-1:LOW_W];
  assign aux_mode_eff = cfg_eff.split ? cfg_eff.aux_mode : TM_STOP;

  etu_down_counter #(.W(MAIN_W)) u_main (
    .clk(clk), .rst(rst), .tick(etu_tick), .start_bit(start_bit),
    .arm(cfg_we), .mode(cfg_eff.main_mode), .load_val(main_load),
    .fire(main_fire)
  );

  etu_down_counter #(.W(BYTE_W)) u_aux (
    .clk(clk), .rst(rst), .tick(etu_tick), .start_bit(start_bit),
    .arm(cfg_we), .mode(aux_mode_eff), .load_val(aux_load),
    .fire(aux_fire)
  );

  always_comb begin
    main_n = main_fire | (exp_main & ~stat_rd);
    aux_n  = aux_fire  | (exp_aux  & ~stat_rd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_main <= 1'b0;
      exp_aux  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      exp_main <= main_n;
      exp_aux  <= aux_n;
      irq      <= main_n | aux_n;
    end
  end
endmodule

// File: rtl/etu_timeout_chk.sv
module etu_timeout_chk (
  input logic clk,
  input logic rst,
  input logic stat_rd,
  input logic exp_main,
  input logic exp_aux,
  input logic irq,
  input logic main_expire,
  input logic aux_expire,
  input logic split_q
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && !exp_main && !exp_aux));

  assert_fire_sets_R3: assert property (@(posedge clk) disable iff (rst)
    main_expire |=> exp_main);

  assert_aux_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !split_q |-> !aux_expire);

  assert_sticky_main_R8: assert property (@(posedge clk) disable iff (rst)
    (exp_main && !stat_rd) |=> exp_main);

  assert_sticky_aux_R8: assert property (@(posedge clk) disable iff (rst)
    (exp_aux && !stat_rd) |=> exp_aux);

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !main_expire && !aux_expire) |=> (!exp_main && !exp_aux));

  assert_irq_or_R9: assert property (@(posedge clk) disable iff (rst)
    irq == (exp_main || exp_aux));
endmodule

bind etu_timeout etu_timeout_chk u_chk (
  .clk(clk), .rst(rst), .stat_rd(stat_rd), .exp_main(exp_main),
  .exp_aux(exp_aux), .irq(irq), .main_expire(main_fire),
  .aux_expire(aux_fire), .split_q(cfg_split)
);

// File: tb/etu_timeout_bench.sv
`timescale 1ns/1ps
module etu_timeout_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       etu_tick = 1'b0, start_bit = 1'b0, wr_en = 1'b0, stat_rd = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       exp_main, exp_aux, irq;

  int checks = 0, fails = 0;
  bit finished = 0;

  // bench model state
  int   m_cnt[2], m_mode[2];
  bit   m_run[2], m_wait[2], m_auto[2], m_flag[2];
  logic [7:0] m_lo, m_mid, m_hi, m_cfg;

  always #2 clk = ~clk;

  etu_timeout u_etu_timeout (
    .clk(clk), .rst(rst), .etu_tick(etu_tick), .start_bit(start_bit),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .stat_rd(stat_rd),
    .exp_main(exp_main), .exp_aux(exp_aux), .irq(irq)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic upd(input int i, input bit arm, input int mode, input int load,
                     input bit tk, input bit sb, output bit e);
    e = 0;
    if (arm) begin
      m_cnt[i] = load; m_mode[i] = mode;
      m_run[i] = (mode == 1 || mode == 3); m_wait[i] = (mode == 2); m_auto[i] = (mode == 3);
    end else if (m_wait[i] && sb) begin
      m_run[i] = 1; m_wait[i] = 0; m_cnt[i] = load;
    end else if (m_run[i] && tk) begin
      if (m_cnt[i] <= 1) begin
        e = 1;
        if (m_auto[i]) m_cnt[i] = load; else m_run[i] = 0;
      end else m_cnt[i]--;
    end
  endtask

  function automatic string mtag(input int mode);
    case (mode)
      1: return "R3";
      2: return "R5";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic step(input bit we, input logic [1:0] a, input logic [7:0] d,
                      input bit sr, input bit tk, input bit sb);
    bit cw, sp, e0, e1;
    int l0, l1, mm, am;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; stat_rd = sr; etu_tick = tk; start_bit = sb;
    @(posedge clk);
    cw = we && a == 2'd3;
    sp = cw ? d[4] : m_cfg[4];
    mm = cw ? int'(d[1:0]) : int'(m_cfg[1:0]);
    am = sp ? (cw ? int'(d[3:2]) : int'(m_cfg[3:2])) : 0;
    l0 = sp ? int'({m_mid, m_lo}) : int'({m_hi, m_mid, m_lo});
    l1 = int'(m_hi);
    upd(0, cw, mm, l0, tk, sb, e0);
    upd(1, cw, am, l1, tk, sb, e1);
    m_flag[0] = e0 | (m_flag[0] & !sr);
    m_flag[1] = e1 | (m_flag[1] & !sr);
    if (we) case (a)
      2'd0: m_lo = d;
      2'd1: m_mid = d;
      2'd2: m_hi = d;
      default: m_cfg = d;
    endcase
    #1;
    chk(mtag(m_mode[0]), exp_main, m_flag[0]);
    chk("R4", exp_aux, m_flag[1]);
    chk("R9", irq, m_flag[0] | m_flag[1]);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d); step(1, a, d, 0, 0, 0); endtask
  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) step(0, 2'd0, 8'd0, 0, 1, 0);
  endtask
  task automatic rd(); step(0, 2'd0, 8'd0, 1, 0, 0); endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 2; i++) begin
      m_cnt[i] = 0; m_mode[i] = 0; m_run[i] = 0; m_wait[i] = 0; m_auto[i] = 0; m_flag[i] = 0;
    end
    m_lo = 0; m_mid = 0; m_hi = 0; m_cfg = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1", exp_main, 1'b0);
    chk("R1", exp_aux, 1'b0);
    chk("R1", irq, 1'b0);

    // R1/R11: zero count after reset expires on the first tick
    wr(2'd3, 8'h01);
    ticks(1);
    chk("R11", exp_main, 1'b1);
    rd();
    chk("R8", exp_main, 1'b0);

    // R3: 24-bit count of 259
    wr(2'd0, 8'd3); wr(2'd1, 8'd1); wr(2'd3, 8'h01);
    ticks(258);
    chk("R3", exp_main, 1'b0);
    ticks(1);
    chk("R3", exp_main, 1'b1);
    rd();
    // R10: one-shot stays stopped
    ticks(300);
    chk("R10", exp_main, 1'b0);

    // R2: bits 23:16 come from address 2 in unsplit mode
    wr(2'd0, 8'd0); wr(2'd1, 8'd0); wr(2'd2, 8'd1); wr(2'd3, 8'h01);
    ticks(65535);
    chk("R2", exp_main, 1'b0);
    ticks(1);
    chk("R2", exp_main, 1'b1);
    rd();

    // R4: split, main 10, aux 4
    wr(2'd0, 8'd10); wr(2'd2, 8'd4); wr(2'd3, 8'h15);
    ticks(3);
    chk("R4", exp_aux, 1'b0);
    ticks(1);
    chk("R4", exp_aux, 1'b1);
    chk("R4", exp_main, 1'b0);
    ticks(6);
    chk("R4", exp_main, 1'b1);
    rd();

    // R5: start-bit mode
    wr(2'd2, 8'd0); wr(2'd0, 8'd4); wr(2'd3, 8'h02);
    ticks(10);
    chk("R5", exp_main, 1'b0);
    step(0, 2'd0, 8'd0, 0, 0, 1);
    ticks(3);
    chk("R5", exp_main, 1'b0);
    ticks(1);
    chk("R5", exp_main, 1'b1);
    rd();

    // R6: auto-reload with reload from current registers
    wr(2'd0, 8'd3); wr(2'd3, 8'h03);
    ticks(3);
    chk("R6", exp_main, 1'b1);
    wr(2'd0, 8'd2); rd();
    ticks(2);
    chk("R6", exp_main, 1'b0);
    ticks(1);
    chk("R6", exp_main, 1'b1);
    rd();
    ticks(2);
    chk("R6", exp_main, 1'b1);

    // R7: stop keeps flag, halts counting
    wr(2'd3, 8'h00);
    ticks(10);
    chk("R7", exp_main, 1'b1);
    rd();
    ticks(10);
    chk("R7", exp_main, 1'b0);

    // R8: expiry and read in the same cycle
    wr(2'd0, 8'd2); wr(2'd3, 8'h01);
    ticks(1);
    step(0, 2'd0, 8'd0, 1, 1, 0);
    chk("R8", exp_main, 1'b1);
    rd();
    chk("R8", exp_main, 1'b0);

    // R11: config write beats a tick in the same cycle
    wr(2'd0, 8'd1);
    step(1, 2'd3, 8'h01, 0, 1, 0);
    chk("R11", exp_main, 1'b0);
    ticks(1);
    chk("R11", exp_main, 1'b1);
    rd();

    // random phase against the model
    for (int n = 0; n < 4000; n++) begin
      bit we, sr, tk, sb;
      logic [1:0] a;
      logic [7:0] d;
      we = ($urandom % 10) == 0;
      a  = 2'($urandom % 4);
      case (a)
        2'd0: d = 8'($urandom % 6);
        2'd3: d = 8'($urandom & 32'h1f);
        default: d = (($urandom % 4) == 0) ? 8'd1 : 8'd0;
      endcase
      sr = ($urandom % 8) == 0;
      tk = ($urandom % 2) == 0;
      sb = ($urandom % 20) == 0;
      step(we, a, d, sr, tk, sb);
    end

    finished = 1;
    summary();
  end
endmodule